// File: doc/BRIEF.md
# UART Bit-Rate Clock Generator

This block derives the two timing signals a UART needs from a single master clock source. It produces an oversampling enable for the receiver, which fires sixteen times per bit, and a square-wave bit clock for the transmitter. The master source is either every cycle of the system clock or the rising edges of an external pin. The external pin is synchronized into the system clock domain, so the whole block runs on one clock.

The master events pass through three stages in turn. The first is a programmable integer prescaler (divide by 2 to 64). The second is a fixed divide-by-two. The third is a selectable power-of-two divider (1 to 128). The output of the last stage is the 16x enable. A final stage counts those enables and toggles the bit clock every eight of them, so the bit clock has an exactly symmetric duty cycle.

A global enable stops and clears all divider stages. Changing any rate or source setting restarts every counter from zero, so the first period after a change has full length.

Top module: `baud_clkgen`

## Requirements
- R1: After reset, `tick16` and `clk1x` are both low.
- R2: `preDiv` holds N-1 for a prescale ratio N (2 to 64). A value of 0 is treated as N=2.
- R3: The prescaler output is always divided by a fixed two before tap selection, so one tap-stage event takes 2*N master events.
- R4: `tapSel` values 0 to 7 select tap divisors 1, 2, 4, 8, 16, 32, 64 and 128 in that order. `tick16` then pulses once every P = 2*N*2^tapSel master events.
- R5: `tick16` is a single-cycle pulse and is never high in two consecutive cycles.
- R6: `clk1x` toggles once every 8 `tick16` pulses. It is therefore high for 8*P cycles and low for 8*P cycles, and it rises only in the cycle after a `tick16` pulse.
- R7: With `extSel`=1, each rising edge of `extClk`, taken through a two-flop synchronizer, is one master event. With `extSel`=0, every enabled system clock cycle is a master event and `extClk` has no effect.
- R8: While `enable` is low, every divider is held cleared, `tick16` stays low and `clk1x` is driven low.
- R9: A change of `preDiv`, `tapSel` or `extSel` clears all dividers. With the internal source, the first `tick16` is then seen P+1 cycles after the cycle in which the new value is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable; low stops and clears all dividers |
| preDiv | input | 6 | Prescale ratio minus one |
| tapSel | input | 3 | Power-of-two tap select, divisor 2^tapSel |
| extSel | input | 1 | 1 selects the external pin as the master source |
| extClk | input | 1 | External master clock pin (asynchronous) |
| tick16 | output | 1 | 16x oversampling enable, one cycle wide |
| clk1x | output | 1 | Symmetric 1x bit clock |

## Verification
On every cycle, the assertions check the following:
- `tick16` is a single-cycle pulse.
- `clk1x` rises only after a `tick16` pulse.
- Both outputs fall silent the cycle after `enable` drops.
- The prescale counter stays within its programmed bound.
- External master events never occur back to back.

Only the bench scenarios can show the numeric rates. These are the `tick16` period for each prescale and tap setting, the 8P high and low times of `clk1x`, the period under an external clock of known rate, and the exact restart latency after a setting change.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Strobes from the control side to the divider datapath
  typedef struct packed {
    logic clr; // clear every divider counter this cycle
    logic ev;  // one master-clock event this cycle
  } baudStb_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int TAP_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [PRE_W-1:0]     preDiv,
  input  logic [TAP_SEL_W-1:0] tapSel,
  input  logic                 extSel,
  input  logic                 extClk,
  output baudStb_t             stb
);
  localparam int CFG_W = PRE_W + TAP_SEL_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic                   extEdge;
  logic [CFG_W-1:0]       cfgNow, cfgQ;
  logic                   cfgChg;

  // external pin synchronizer chain
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else if (i == 0) syncQ[i] <= extClk;
        else syncQ[i] <= syncQ[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else extPrev <= syncQ[SYNC_STAGES-1];
  end

  assign extEdge = syncQ[SYNC_STAGES-1] && !extPrev;

  // configuration change detection
  assign cfgNow = {preDiv, tapSel, extSel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else cfgQ <= cfgNow;
  end

  assign cfgChg = (cfgNow != cfgQ);

  always_comb begin
    stb.clr = !enable || cfgChg;
    stb.ev  = enable && !cfgChg && (extSel ? extEdge : 1'b1);
  end

  // R7: a synchronized external edge cannot repeat in the next cycle
  a_r7_ext_event_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && stb.ev) |=> !stb.ev);

  // R8: no master events while disabled
  a_r8_no_event_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !stb.ev);
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int PRE_W     = 6,
  parameter int TAP_SEL_W = 3,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  baudStb_t             stb,
  input  logic [PRE_W-1:0]     preDiv,
  input  logic [TAP_SEL_W-1:0] tapSel,
  output logic                 tick16,
  output logic                 clk1x
);
  localparam int TAP_CNT_W = (1 << TAP_SEL_W) - 1;
  localparam int HALF_OVS  = OVS / 2;
  localparam int SUB_W     = $clog2(HALF_OVS);

  logic [PRE_W-1:0]     preCnt, preMax;
  logic                 half;
  logic [TAP_CNT_W-1:0] tapCnt, tapMax;
  logic [SUB_W-1:0]     subCnt;
  logic                 preHit, halfHit, tapHit;

  assign preMax  = (preDiv == '0) ? PRE_W'(1) : preDiv;
  assign tapMax  = TAP_CNT_W'((32'd1 << tapSel) - 32'd1);
  assign preHit  = stb.ev && (preCnt == preMax);
  assign halfHit = preHit && half;
  assign tapHit  = halfHit && (tapCnt == tapMax);

  // integer prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (stb.clr) preCnt <= '0;
    else if (preHit) preCnt <= '0;
    else if (stb.ev) preCnt <= preCnt + PRE_W'(1);
  end

  // fixed divide-by-two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) half <= 1'b0;
    else if (stb.clr) half <= 1'b0;
    else if (preHit) half <= !half;
  end

  // power-of-two tap divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tapCnt <= '0;
    else if (stb.clr) tapCnt <= '0;
    else if (tapHit) tapCnt <= '0;
    else if (halfHit) tapCnt <= tapCnt + TAP_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tick16 <= 1'b0;
    else if (stb.clr) tick16 <= 1'b0;
    else tick16 <= tapHit;
  end

  // symmetric 1x clock: toggle every HALF_OVS oversampling ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      clk1x  <= 1'b0;
    end else if (stb.clr) begin
      subCnt <= '0;
      clk1x  <= 1'b0;
    end else if (tick16) begin
      if (subCnt == SUB_W'(HALF_OVS - 1)) begin
        subCnt <= '0;
        clk1x  <= !clk1x;
      end else begin
        subCnt <= subCnt + SUB_W'(1);
      end
    end
  end

  // R2: prescale count stays within the programmed ratio
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rstN || stb.clr)
    preCnt <= preMax);

  // R5: oversampling enable is one cycle wide
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    tick16 |=> !tick16);

  // R6: the bit clock rises only right after an oversampling tick
  a_r6_rise_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clk1x) |-> $past(tick16));

  // R8/R9: a clear silences both outputs on the next edge
  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (!tick16 && !clk1x));
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int TAP_SEL_W   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int OVS         = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [PRE_W-1:0]     preDiv,
  input  logic [TAP_SEL_W-1:0] tapSel,
  input  logic                 extSel,
  input  logic                 extClk,
  output logic                 tick16,
  output logic                 clk1x
);
  baudStb_t stb;

  baud_ctrl #(
    .PRE_W(PRE_W), .TAP_SEL_W(TAP_SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .preDiv(preDiv),
    .tapSel(tapSel), .extSel(extSel), .extClk(extClk), .stb(stb)
  );

  baud_datapath #(
    .PRE_W(PRE_W), .TAP_SEL_W(TAP_SEL_W), .OVS(OVS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .preDiv(preDiv), .tapSel(tapSel),
    .tick16(tick16), .clk1x(clk1x)
  );
endmodule

// File: tb/baud_clkgen_tb.sv
`timescale 1ns/1ps
module baud_clkgen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [5:0] preDiv = 6'd1;
  logic [2:0] tapSel = 3'd0;
  logic       extSel = 1'b0;
  logic       extClk = 1'b0;
  logic       tick16, clk1x;

  int nTests = 0;
  int nFail  = 0;
  int extHalf = 0; // 0 = external clock stopped

  always #2 clk = !clk; // 250 MHz

  baud_clkgen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .preDiv(preDiv),
    .tapSel(tapSel), .extSel(extSel), .extClk(extClk),
    .tick16(tick16), .clk1x(clk1x)
  );

  // external clock source, toggles on negedges
  initial begin
    forever begin
      @(negedge clk);
      if (extHalf > 0) begin
        repeat (extHalf - 1) @(negedge clk);
        extClk = !extClk;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cycles until next tick16 sampled high, bounded
  task automatic waitTick(output int n);
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      n++;
      if (tick16) return;
    end
    n = -1;
  endtask

  task automatic measPeriod(input string req, input int exp);
    int n;
    waitTick(n);
    waitTick(n);
    check(req, n, exp);
    waitTick(n);
    check(req, n, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 tick16 reset", int'(tick16), 0);
    check("R1 clk1x reset", int'(clk1x), 0);
  endtask

  task automatic setCfg(input int pd, input int ts);
    @(negedge clk);
    preDiv = 6'(pd);
    tapSel = 3'(ts);
  endtask

  task automatic testRates();
    setCfg(1, 0);  measPeriod("R3 N=2 tap1", 4);
    setCfg(0, 0);  measPeriod("R2 field0 as N=2", 4);
    setCfg(4, 0);  measPeriod("R2 N=5", 10);
    setCfg(63, 0); measPeriod("R2 N=64", 128);
    setCfg(2, 3);  measPeriod("R4 N=3 tap8", 48);
    setCfg(1, 7);  measPeriod("R4 N=2 tap128", 512);
    // extClk toggling must not disturb the internal source
    extHalf = 3;
    setCfg(2, 1);  measPeriod("R7 ext ignored internal", 12);
    extHalf = 0;
  endtask

  task automatic testSinglePulse();
    int n;
    setCfg(1, 0);
    waitTick(n);
    @(negedge clk);
    check("R5 pulse one cycle", int'(tick16), 0);
  endtask

  task automatic testOneX();
    int hi, lo;
    setCfg(1, 0); // P = 4
    for (int i = 0; i < 200 && !clk1x; i++) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 200 && clk1x; i++) begin hi++; @(negedge clk); end
    lo = 0;
    for (int i = 0; i < 200 && !clk1x; i++) begin lo++; @(negedge clk); end
    check("R6 clk1x high time", hi, 32);
    check("R6 clk1x low time", lo, 32);
  endtask

  task automatic testExternal();
    extHalf = 2; // period 4 cycles
    @(negedge clk);
    extSel = 1'b1;
    preDiv = 6'd1;
    tapSel = 3'd0;
    measPeriod("R7 ext N=2 tap1", 16);
    tapSel = 3'd1;
    measPeriod("R7 ext N=2 tap2", 32);
    @(negedge clk);
    extSel = 1'b0;
    extHalf = 0;
  endtask

  task automatic testDisable();
    int cnt, hi;
    setCfg(1, 0);
    @(negedge clk);
    enable = 1'b0;
    cnt = 0; hi = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i > 0 && tick16) cnt++;
      if (i > 0 && clk1x) hi++;
    end
    check("R8 no ticks disabled", cnt, 0);
    check("R8 clk1x low disabled", hi, 0);
    enable = 1'b1;
    measPeriod("R8 resumes after enable", 4);
  endtask

  task automatic testRestart();
    int n;
    setCfg(1, 0);
    repeat (3) @(negedge clk);
    preDiv = 6'd4;
    tapSel = 3'd1; // P = 2*5*2 = 20
    waitTick(n);
    check("R9 restart latency", n, 21);
    tapSel = 3'd2; // P = 40, changed right at a tick
    waitTick(n);
    check("R9 restart latency tap", n, 41);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    enable = 1'b1;
    testRates();
    testSinglePulse();
    testOneX();
    testExternal();
    testDisable();
    testRestart();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule